// File: doc/BRIEF.md
# Predicated Data-Processing ALU

This block is the execute stage of a small processor's data path. In one cycle it evaluates one of sixteen data-processing operations on a first source operand and on a second operand that has already passed through the barrel shifter. It then decides whether the destination register is written and computes the condition flags that follow. The operations are bitwise logic, moves, add and subtract in both operand orders, carry-chained forms for multi-word arithmetic, and four test/compare forms that only affect flags. The block is purely combinational.

Every operation is predicated on a 4-bit condition field, which is tested against the incoming flags. When the condition fails, nothing is committed: the destination write is withheld and the flags pass through unchanged. When the condition holds and the set-flags input is high, the negative and zero flags follow the result. Carry and overflow come from the adder for arithmetic operations. For logical operations carry comes from the shifter and overflow is kept. Operand fetch, the register file and the flag register itself sit outside this block.

Top module: `dpu_alu`

## Requirements
- R1: Logical opcodes give: 0000 src_a AND src_b, 0001 src_a XOR src_b, 1100 src_a OR src_b, 1101 src_b, 1110 src_a AND NOT src_b, 1111 NOT src_b. The test forms 1000 and 1001 put AND and XOR on `result`.
- R2: Arithmetic opcodes give, modulo 2^DW (c is flags_in bit 1): 0100 a+b, 0101 a+b+c, 0010 a−b, 0110 a−b+c−1, 0011 b−a, 0111 b−a+c−1, 1010 a−b, 1011 a+b.
- R3: Opcodes 1000 through 1011 never assert `dest_we`. Every other opcode asserts `dest_we` whenever the condition passes.
- R4: With `set_flags` low, `flags_out` equals `flags_in`. The flag bit order is N=3, Z=2, C=1, V=0.
- R5: With `set_flags` high and the condition passing, N is result bit DW−1 and Z is 1 exactly when the result is all zeros.
- R6: For arithmetic opcodes that update flags, C is the unsigned carry out of the addition. For subtract forms this means C=1 when no borrow occurs.
- R7: For arithmetic opcodes that update flags, V is 1 exactly when the true signed result falls outside the DW-bit two's-complement range.
- R8: For logical opcodes that update flags, C equals `sh_carry` and V keeps its value from `flags_in`.
- R9: The condition passes by code: 0000 Z, 0001 !Z, 0010 C, 0011 !C, 0100 N, 0101 !N, 0110 V, 0111 !V, 1000 C&!Z, 1001 !C|Z, 1010 N==V, 1011 N!=V, 1100 !Z&(N==V), 1101 Z|(N!=V), 1110 always, 1111 never.
- R10: A failed condition forces `dest_we` low and makes `flags_out` equal `flags_in`, whatever the opcode and `set_flags`.
- R11: Opcodes 1101 and 1111 do not depend on `src_a`. Their result and flags are identical for any `src_a` value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_code | input | 4 | Operation select |
| set_flags | input | 1 | Allow the flags to be updated |
| cond_field | input | 4 | Predicate code tested against `flags_in` |
| src_a | input | DW | First source operand |
| src_b | input | DW | Shifted second operand |
| sh_carry | input | 1 | Carry out of the shifter |
| flags_in | input | 4 | Current N,Z,C,V |
| result | output | DW | Operation result |
| dest_we | output | 1 | Destination register write enable |
| flags_out | output | 4 | Next N,Z,C,V |

## Verification
The bench builds the block with DW=8. At that width the sign boundary (0x7F/0x80), the all-ones wrap and the zero result can all be reached from a compact set of sixteen operand values. It crosses that set with all sixteen opcodes, both carry inputs, both shifter carries and both settings of `set_flags`. The expected values come from signed and unsigned integer arithmetic, not from an adder model. The condition decoder is swept exhaustively over all 16 codes and all 16 flag combinations, and a separate sweep varies `src_a` under the move opcodes.

// File: rtl/dpu_pkg.sv
`timescale 1ns/1ps
package dpu_pkg;

  typedef enum logic [3:0] {
    OP_AND = 4'h0, OP_EOR = 4'h1, OP_SUB = 4'h2, OP_RSB = 4'h3,
    OP_ADD = 4'h4, OP_ADC = 4'h5, OP_SBC = 4'h6, OP_RSC = 4'h7,
    OP_TST = 4'h8, OP_TEQ = 4'h9, OP_CMP = 4'hA, OP_CMN = 4'hB,
    OP_ORR = 4'hC, OP_MOV = 4'hD, OP_BIC = 4'hE, OP_MVN = 4'hF
  } dp_op_e;

  localparam int FLG_N = 3;
  localparam int FLG_Z = 2;
  localparam int FLG_C = 1;
  localparam int FLG_V = 0;

  // Opcodes whose carry comes from the shifter and whose V is kept
  function automatic logic f_is_logic(input logic [3:0] op);
    case (op)
      OP_AND, OP_EOR, OP_TST, OP_TEQ,
      OP_ORR, OP_MOV, OP_BIC, OP_MVN: f_is_logic = 1'b1;
      default:                        f_is_logic = 1'b0;
    endcase
  endfunction

  // Test/compare forms write flags only
  function automatic logic f_writes_dest(input logic [3:0] op);
    f_writes_dest = (op[3:2] != 2'b10);
  endfunction

  function automatic logic f_cond_pass(input logic [3:0] cc, input logic [3:0] nzcv);
    logic n, z, c, v;
    n = nzcv[FLG_N];
    z = nzcv[FLG_Z];
    c = nzcv[FLG_C];
    v = nzcv[FLG_V];
    case (cc)
      4'h0:    f_cond_pass = z;
      4'h1:    f_cond_pass = !z;
      4'h2:    f_cond_pass = c;
      4'h3:    f_cond_pass = !c;
      4'h4:    f_cond_pass = n;
      4'h5:    f_cond_pass = !n;
      4'h6:    f_cond_pass = v;
      4'h7:    f_cond_pass = !v;
      4'h8:    f_cond_pass = c & !z;
      4'h9:    f_cond_pass = !c | z;
      4'hA:    f_cond_pass = (n == v);
      4'hB:    f_cond_pass = (n != v);
      4'hC:    f_cond_pass = !z & (n == v);
      4'hD:    f_cond_pass = z | (n != v);
      4'hE:    f_cond_pass = 1'b1;
      default: f_cond_pass = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/dpu_cond_eval.sv
`timescale 1ns/1ps
module dpu_cond_eval
  import dpu_pkg::*;
(
  input  logic [3:0] cond_field,
  input  logic [3:0] flags_in,
  output logic       cond_ok
);

  assign cond_ok = f_cond_pass(cond_field, flags_in);

  always_comb begin
    AST_COND_ALWAYS: assert (!(cond_field == 4'hE) || cond_ok)
      else $error("always code did not pass"); // R9
    AST_COND_NEVER: assert (!(cond_field == 4'hF) || !cond_ok)
      else $error("never code passed"); // R9
    AST_COND_EQ: assert (!(cond_field == 4'h0) || (cond_ok == flags_in[FLG_Z]))
      else $error("equal code disagrees with Z"); // R9
  end

endmodule

// File: rtl/dpu_adder.sv
`timescale 1ns/1ps
module dpu_adder
  import dpu_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [3:0]    op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          cin,
  output logic [DW-1:0] sum,
  output logic          cout,
  output logic          ovf
);

  localparam int MSB = DW - 1;

  logic [DW-1:0] x, y;
  logic          ci;
  logic [DW:0]   wide;

  // One adder serves every arithmetic form: subtraction adds the
  // inverted subtrahend, reverse forms swap the operands first.
  always_comb begin
    x  = a;
    y  = b;
    ci = 1'b0;
    case (op)
      OP_ADC:         ci = cin;
      OP_SUB, OP_CMP: begin y = ~b; ci = 1'b1; end
      OP_SBC:         begin y = ~b; ci = cin;  end
      OP_RSB:         begin x = b;  y = ~a; ci = 1'b1; end
      OP_RSC:         begin x = b;  y = ~a; ci = cin;  end
      default:        ;
    endcase
  end

  assign wide = {1'b0, x} + {1'b0, y} + {{DW{1'b0}}, ci};
  assign sum  = wide[DW-1:0];
  assign cout = wide[DW];
  assign ovf  = (x[MSB] == y[MSB]) && (sum[MSB] != x[MSB]);

  always_comb begin
    AST_SUB_EQUAL: assert (!((op == OP_SUB || op == OP_CMP) && a == b) || (cout && sum == '0))
      else $error("equal subtract must give zero with no borrow"); // R6
    AST_ADD_NOWRAP: assert (!(op == OP_ADD && !cout) || (sum >= a))
      else $error("add without carry went below first operand"); // R2
    AST_ADD_OVF_SIGN: assert (!(op == OP_ADD && ovf) || (a[MSB] == b[MSB]))
      else $error("add overflow with differing operand signs"); // R7
  end

endmodule

// File: rtl/dpu_logic.sv
`timescale 1ns/1ps
module dpu_logic
  import dpu_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [3:0]    op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] out
);

  always_comb begin
    case (op)
      OP_AND, OP_TST: out = a & b;
      OP_EOR, OP_TEQ: out = a ^ b;
      OP_ORR:         out = a | b;
      OP_MOV:         out = b;
      OP_BIC:         out = a & ~b;
      OP_MVN:         out = ~b;
      default:        out = '0;
    endcase
  end

  always_comb begin
    AST_MOVE_NOT: assert (!(op == OP_MVN) || ((out ^ b) == '1))
      else $error("inverted move is not the complement"); // R1
  end

endmodule

// File: rtl/dpu_alu.sv
`timescale 1ns/1ps
module dpu_alu
  import dpu_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [3:0]    op_code,
  input  logic          set_flags,
  input  logic [3:0]    cond_field,
  input  logic [DW-1:0] src_a,
  input  logic [DW-1:0] src_b,
  input  logic          sh_carry,
  input  logic [3:0]    flags_in,
  output logic [DW-1:0] result,
  output logic          dest_we,
  output logic [3:0]    flags_out
);

  localparam int MSB = DW - 1;

  logic [DW-1:0] add_res, log_res;
  logic          add_c, add_v;
  logic          cond_ok;
  logic          is_arith;
  logic          flag_upd;

  dpu_cond_eval u_cond (
    .cond_field (cond_field),
    .flags_in   (flags_in),
    .cond_ok    (cond_ok)
  );

  dpu_adder #(.DW(DW)) u_add (
    .op   (op_code),
    .a    (src_a),
    .b    (src_b),
    .cin  (flags_in[FLG_C]),
    .sum  (add_res),
    .cout (add_c),
    .ovf  (add_v)
  );

  dpu_logic #(.DW(DW)) u_log (
    .op  (op_code),
    .a   (src_a),
    .b   (src_b),
    .out (log_res)
  );

  assign is_arith = !f_is_logic(op_code);
  assign result   = is_arith ? add_res : log_res;
  assign dest_we  = cond_ok && f_writes_dest(op_code);
  assign flag_upd = cond_ok && set_flags;

  always_comb begin
    flags_out = flags_in;
    if (flag_upd) begin
      flags_out[FLG_N] = result[MSB];
      flags_out[FLG_Z] = (result == '0);
      flags_out[FLG_C] = is_arith ? add_c : sh_carry;
      flags_out[FLG_V] = is_arith ? add_v : flags_in[FLG_V];
    end
  end

  always_comb begin
    AST_CMP_NO_WRITE: assert (!(op_code[3:2] == 2'b10) || !dest_we)
      else $error("compare form wrote destination"); // R3
    AST_FLAGS_HELD: assert (set_flags || (flags_out == flags_in))
      else $error("flags moved with set_flags low"); // R4
    AST_ZERO_FLAG: assert (!(flag_upd && result == '0) || flags_out[FLG_Z])
      else $error("zero result without Z"); // R5
    AST_LOGIC_KEEPS_V: assert (is_arith || (flags_out[FLG_V] == flags_in[FLG_V]))
      else $error("logical opcode changed V"); // R8
    AST_FAIL_QUIET: assert (cond_ok || (!dest_we && flags_out == flags_in))
      else $error("failed condition committed state"); // R10
  end

endmodule

// File: tb/sim_dpu_alu.sv
`timescale 1ns/1ps
module sim_dpu_alu;

  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [3:0]    op_code = '0;
  logic          set_flags = 1'b0;
  logic [3:0]    cond_field = 4'hE;
  logic [DW-1:0] src_a = '0;
  logic [DW-1:0] src_b = '0;
  logic          sh_carry = 1'b0;
  logic [3:0]    flags_in = '0;
  logic [DW-1:0] result;
  logic          dest_we;
  logic [3:0]    flags_out;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  dpu_alu #(.DW(DW)) u0 (
    .op_code, .set_flags, .cond_field, .src_a, .src_b,
    .sh_carry, .flags_in, .result, .dest_we, .flags_out
  );

  function automatic logic [7:0] pick(input int i);
    case (i)
      0: pick = 8'h00;  1: pick = 8'h01;  2: pick = 8'h02;  3: pick = 8'h7F;
      4: pick = 8'h80;  5: pick = 8'h81;  6: pick = 8'hFE;  7: pick = 8'hFF;
      8: pick = 8'h55;  9: pick = 8'hAA; 10: pick = 8'h0F; 11: pick = 8'hF0;
      12: pick = 8'h3C; 13: pick = 8'h40; 14: pick = 8'h7E; default: pick = 8'hC3;
    endcase
  endfunction

  // Predicate model grouped by pairs: odd codes invert the even one
  function automatic bit ref_cond(input logic [3:0] cc, input logic [3:0] f);
    bit n, z, c, v, base;
    n = f[3]; z = f[2]; c = f[1]; v = f[0];
    case (cc[3:1])
      3'd0: base = z;
      3'd1: base = c;
      3'd2: base = n;
      3'd3: base = v;
      3'd4: base = c && !z;
      3'd5: base = (n == v);
      3'd6: base = !z && (n == v);
      default: base = 1'b1;
    endcase
    ref_cond = (cc[3:1] == 3'd7) ? !cc[0] : (base ^ cc[0]);
  endfunction

  // Returns {we, flags[3:0], result[7:0]}
  function automatic logic [12:0] ref_model(input logic [3:0] op, input bit s,
      input logic [3:0] cc, input logic [7:0] a, input logic [7:0] b,
      input bit shc, input logic [3:0] f);
    int ua, ub, sa, sb, u, sv, cin;
    bit arith, sub, c, v, we, pass;
    logic [7:0] r;
    logic [3:0] fo;
    ua = int'(a); ub = int'(b);
    sa = (ua > 127) ? ua - 256 : ua;
    sb = (ub > 127) ? ub - 256 : ub;
    cin = int'(f[1]);
    arith = 1'b1; sub = 1'b0; u = 0; sv = 0; r = '0;
    case (op)
      4'h0, 4'h8: begin arith = 0; r = a & b; end
      4'h1, 4'h9: begin arith = 0; r = a ^ b; end
      4'hC: begin arith = 0; r = a | b; end
      4'hD: begin arith = 0; r = b; end
      4'hE: begin arith = 0; r = a & ~b; end
      4'hF: begin arith = 0; r = ~b; end
      4'h4, 4'hB: begin u = ua + ub; sv = sa + sb; end
      4'h5: begin u = ua + ub + cin; sv = sa + sb + cin; end
      4'h2, 4'hA: begin sub = 1; u = ua - ub; sv = sa - sb; end
      4'h6: begin sub = 1; u = ua - ub - (1 - cin); sv = sa - sb - (1 - cin); end
      4'h3: begin sub = 1; u = ub - ua; sv = sb - sa; end
      default: begin sub = 1; u = ub - ua - (1 - cin); sv = sb - sa - (1 - cin); end
    endcase
    if (arith) r = 8'((u + 512) % 256);
    c = arith ? (sub ? (u >= 0) : (u > 255)) : shc;
    v = arith ? (sv > 127 || sv < -128) : f[0];
    pass = ref_cond(cc, f);
    we = pass && !(op >= 4'h8 && op <= 4'hB);
    fo = (pass && s) ? {r[7], (r == 8'h00), c, v} : f;
    ref_model = {we, fo, r};
  endfunction

  task automatic run(input logic [3:0] op, input bit s, input logic [3:0] cc,
      input logic [7:0] a, input logic [7:0] b, input bit shc,
      input logic [3:0] f, input string tag);
    logic [12:0] exp;
    @(posedge clk);
    #1;
    op_code = op; set_flags = s; cond_field = cc;
    src_a = a; src_b = b; sh_carry = shc; flags_in = f;
    exp = ref_model(op, s, cc, a, b, shc, f);
    @(negedge clk);
    n_vec++;
    if ({dest_we, flags_out, result} !== exp) begin
      n_bad++;
      $display("FAIL %s op=%h s=%0d cc=%h a=%h b=%h shc=%0d f=%b : got we=%0d fl=%b res=%h exp we=%0d fl=%b res=%h",
               tag, op, s, cc, a, b, shc, f, dest_we, flags_out, result,
               exp[12], exp[11:8], exp[7:0]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    string tag;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // Reset-state inputs: AND of zeros, flags held
    run(4'h0, 1'b0, 4'hE, 8'h00, 8'h00, 1'b0, 4'h0, "R1 R4 reset");

    // Main sweep over opcodes, operand corners, carries and S
    for (int op = 0; op < 16; op++) begin
      for (int i = 0; i < 16; i++) begin
        for (int j = 0; j < 16; j++) begin
          for (int k = 0; k < 4; k++) begin
            logic [7:0] a, b;
            logic [3:0] f;
            a = pick(i);
            b = pick(j);
            f = {a[7], b[0], k[0] ? 1'b1 : 1'b0, a[1] ^ b[2]};
            if (op inside {0, 1, 8, 9, 12, 13, 14, 15})
              tag = "R1 R3 R5 R8";
            else
              tag = "R2 R3 R5 R6 R7";
            if (k[1] == 1'b0) tag = {tag, " R4"};
            run(4'(op), k[1], 4'hE, a, b, k[0] ^ a[0], f, tag);
          end
        end
      end
    end

    // Exhaustive predicate sweep, with both a writing and a compare opcode
    for (int cc = 0; cc < 16; cc++) begin
      for (int f = 0; f < 16; f++) begin
        run(4'h4, 1'b1, 4'(cc), 8'h03, 8'h04, 1'b0, 4'(f), "R9 R10");
        run(4'hA, 1'b1, 4'(cc), 8'h80, 8'h01, 1'b1, 4'(f), "R9 R10 R3");
      end
    end

    // Move forms must not see src_a
    for (int i = 0; i < 256; i++) begin
      run(4'hD, 1'b1, 4'hE, 8'(i), 8'h5A, 1'b1, 4'b0101, "R11");
      run(4'hF, 1'b1, 4'hE, 8'(i), 8'h00, 1'b0, 4'b1010, "R11");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule